// File: doc/BRIEF.md
# Word Multiplier with Register-Pair Writeback

This block multiplies the low words of two operands, either both signed or both unsigned, and returns the exact double-width product. It steps through one multiplier bit per clock, so a product is ready a fixed number of cycles after the operation is accepted. It then places the result on up to two register-file write ports.

The write routing depends on the register width mode. With narrow (32-bit) registers the product does not fit in one register, so it is split. The low half goes to the even register of an aligned pair and the high half goes to the odd register. The pair is chosen by the upper four bits of the destination index. With wide (64-bit) registers the whole product goes to the single destination register. The register file and instruction decode sit outside the block. Writes aimed at register 0 are still driven out, and dropping them is the register file's job.

Top module: `wordmul_pair`

## Requirements
- R1: With `is_signed` low, both operand low words are zero-extended, and the product is the exact 64-bit unsigned result.
- R2: With `is_signed` high, both operand low words are taken as two's complement, and the product is the exact 64-bit signed result, including for the most negative value.
- R3: Operand bits 63:32 have no effect on the result.
- R4: With `mode64` low, port 0 writes address {rd[4:1],0} with product bits 31:0, and port 1 writes address {rd[4:1],1} with product bits 63:32. Data bits 63:32 of both ports are zero, and rd bit 0 is ignored.
- R5: With `mode64` high, port 0 writes address rd with the full 64-bit product, and `wr1_en` stays low.
- R6: A start is accepted when the block is idle. `done` rises exactly 32 clock edges after the accepting edge and lasts one cycle. The write enables are high only while `done` is high.
- R7: A start raised while an operation is in progress is ignored. The running result is unchanged, and no extra `done` follows.
- R8: A synchronous reset, `rst` high, aborts any operation and clears `done` and both write enables.
- R9: A destination in register 0 or its pair is not suppressed. In 32-bit mode with rd = 0 or 1, the ports write addresses 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a multiply (taken when idle) |
| is_signed | input | 1 | 1 = signed operands, 0 = unsigned |
| mode64 | input | 1 | 1 = 64-bit registers, 0 = 32-bit register pair |
| op_a | input | 64 | First operand (low word used) |
| op_b | input | 64 | Second operand (low word used) |
| rd | input | 5 | Destination register index |
| done | output | 1 | One-cycle result strobe |
| wr0_en | output | 1 | Write port 0 enable |
| wr0_addr | output | 5 | Write port 0 address |
| wr0_data | output | 64 | Write port 0 data |
| wr1_en | output | 1 | Write port 1 enable |
| wr1_addr | output | 5 | Write port 1 address |
| wr1_data | output | 64 | Write port 1 data |

## Verification
The assertions assume that `rst` is asserted at time zero and held for at least one clock edge, so that the control state is known before any property is evaluated. They assume nothing about `start` timing, since a start while busy is part of the defined behaviour. The stimulus therefore also drives starts during an operation and a reset partway through one. Operands, the signedness select, the mode and rd come from a seeded random generator, with directed extremes added: all-ones, the most negative word, zero, and non-zero upper operand bits.

// File: rtl/wordmul_pkg.sv
package wordmul_pkg;
  localparam int unsigned HALF_W = 32;
  localparam int unsigned PROD_W = 2 * HALF_W;
  localparam int unsigned REG_IDX_W = 5;

  typedef struct packed {
    logic                 en;
    logic [REG_IDX_W-1:0] addr;
    logic [PROD_W-1:0]    data;
  } wr_port_t;
endpackage

// File: rtl/wordmul_seq.sv
module wordmul_seq #(
  parameter int unsigned W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           is_signed,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] prod
);
  localparam int unsigned PW = 2 * W;
  localparam int unsigned CW = $clog2(W);

  function automatic logic [W-1:0] magnitude(input logic [W-1:0] v, input logic sgn);
    return (sgn && v[W-1]) ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [PW-1:0] apply_sign(input logic [PW-1:0] p, input logic neg);
    return neg ? (~p + 1'b1) : p;
  endfunction

  logic [PW-1:0] mcand;
  logic [W-1:0]  mplier;
  logic [PW-1:0] acc;
  logic [CW-1:0] step;
  logic          neg_q;

  logic          accept;
  logic          last_step;
  logic          start_ignored;
  logic [PW-1:0] acc_next;

  assign accept        = start && !busy;
  assign start_ignored = start && busy;
  assign last_step     = busy && (step == CW'(W - 1));
  assign acc_next      = mplier[0] ? (acc + mcand) : acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      step   <= '0;
      acc    <= '0;
      mcand  <= '0;
      mplier <= '0;
      neg_q  <= 1'b0;
      prod   <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy   <= 1'b1;
        step   <= '0;
        acc    <= '0;
        mcand  <= {{W{1'b0}}, magnitude(a, is_signed)};
        mplier <= magnitude(b, is_signed);
        neg_q  <= is_signed && (a[W-1] ^ b[W-1]);
      end else if (busy) begin
        acc    <= acc_next;
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
        step   <= step + 1'b1;
        if (last_step) begin
          busy <= 1'b0;
          done <= 1'b1;
          prod <= apply_sign(acc_next, neg_q);
        end
      end
    end
  end

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_accept_busy_R6: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy && !done);
  assert_ignored_start_R7: assert property (@(posedge clk) disable iff (rst)
    start_ignored |=> $stable(neg_q) && (busy || done));
  assert_reset_clears_R8: assert property (@(posedge clk)
    $past(rst) |-> !busy && !done);
endmodule

// File: rtl/wordmul_wb.sv
module wordmul_wb
  import wordmul_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 done,
  input  logic                 mode64,
  input  logic [REG_IDX_W-1:0] rd,
  input  logic [PROD_W-1:0]    prod,
  output wr_port_t             port0,
  output wr_port_t             port1
);
  logic [REG_IDX_W-1:0] even_addr;
  logic [REG_IDX_W-1:0] odd_addr;
  logic                 pair_write;

  assign even_addr  = {rd[REG_IDX_W-1:1], 1'b0};
  assign odd_addr   = {rd[REG_IDX_W-1:1], 1'b1};
  assign pair_write = done && !mode64;

  always_comb begin
    port0.en   = done;
    port1.en   = pair_write;
    port1.addr = odd_addr;
    port1.data = {{HALF_W{1'b0}}, prod[PROD_W-1:HALF_W]};
    if (mode64) begin
      port0.addr = rd;
      port0.data = prod;
    end else begin
      port0.addr = even_addr;
      port0.data = {{HALF_W{1'b0}}, prod[HALF_W-1:0]};
    end
  end

  assert_pair_addr_R4: assert property (@(posedge clk) disable iff (rst)
    port1.en |-> (port0.addr[0] == 1'b0) && (port1.addr == (port0.addr | 5'd1)));
  assert_pair_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
    port1.en |-> (port0.data[PROD_W-1:HALF_W] == '0) && (port1.data[PROD_W-1:HALF_W] == '0));
  assert_single_port_R5: assert property (@(posedge clk) disable iff (rst)
    (port0.en && mode64) |-> !port1.en && (port0.addr == rd));
  assert_en_gated_R6: assert property (@(posedge clk) disable iff (rst)
    port1.en |-> port0.en);
endmodule

// File: rtl/wordmul_pair.sv
module wordmul_pair
  import wordmul_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 is_signed,
  input  logic                 mode64,
  input  logic [PROD_W-1:0]    op_a,
  input  logic [PROD_W-1:0]    op_b,
  input  logic [REG_IDX_W-1:0] rd,
  output logic                 done,
  output logic                 wr0_en,
  output logic [REG_IDX_W-1:0] wr0_addr,
  output logic [PROD_W-1:0]    wr0_data,
  output logic                 wr1_en,
  output logic [REG_IDX_W-1:0] wr1_addr,
  output logic [PROD_W-1:0]    wr1_data
);
  logic                 busy;
  logic                 accept;
  logic [PROD_W-1:0]    prod;
  logic [REG_IDX_W-1:0] rd_q;
  logic                 mode64_q;
  wr_port_t             p0;
  wr_port_t             p1;
  logic                 unused_upper;

  assign accept       = start && !busy;
  assign unused_upper = ^{op_a[PROD_W-1:HALF_W], op_b[PROD_W-1:HALF_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q     <= '0;
      mode64_q <= 1'b0;
    end else if (accept) begin
      rd_q     <= rd;
      mode64_q <= mode64;
    end
  end

  wordmul_seq #(.W(HALF_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .is_signed (is_signed),
    .a         (op_a[HALF_W-1:0]),
    .b         (op_b[HALF_W-1:0]),
    .busy      (busy),
    .done      (done),
    .prod      (prod)
  );

  wordmul_wb u_wb (
    .clk    (clk),
    .rst    (rst),
    .done   (done),
    .mode64 (mode64_q),
    .rd     (rd_q),
    .prod   (prod),
    .port0  (p0),
    .port1  (p1)
  );

  assign wr0_en   = p0.en;
  assign wr0_addr = p0.addr;
  assign wr0_data = p0.data;
  assign wr1_en   = p1.en;
  assign wr1_addr = p1.addr;
  assign wr1_data = p1.data;

  assert_dest_held_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(rd_q) && $stable(mode64_q));
  assert_enables_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !done |-> !wr0_en && !wr1_en);
endmodule

// File: tb/sim_wordmul_pair.sv
module sim_wordmul_pair;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        is_signed = 1'b0;
  logic        mode64 = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic [4:0]  rd = '0;
  logic        done, wr0_en, wr1_en;
  logic [4:0]  wr0_addr, wr1_addr;
  logic [63:0] wr0_data, wr1_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  wordmul_pair u0 (
    .clk(clk), .rst(rst), .start(start), .is_signed(is_signed), .mode64(mode64),
    .op_a(op_a), .op_b(op_b), .rd(rd), .done(done),
    .wr0_en(wr0_en), .wr0_addr(wr0_addr), .wr0_data(wr0_data),
    .wr1_en(wr1_en), .wr1_addr(wr1_addr), .wr1_data(wr1_data)
  );

  function automatic logic [63:0] ref_prod(input logic sgn, input logic [63:0] a, input logic [63:0] b);
    longint sa, sb;
    if (sgn) begin
      sa = longint'($signed(a[31:0]));
      sb = longint'($signed(b[31:0]));
      return 64'(sa * sb);
    end
    return {32'd0, a[31:0]} * {32'd0, b[31:0]};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  // starts one op; if intrude is set, raises start again mid-run with other operands (R7)
  task automatic run_op(input string tag, input logic sgn, input logic m64,
                        input logic [63:0] a, input logic [63:0] b, input logic [4:0] d,
                        input logic intrude);
    logic [63:0] exp;
    int n;
    logic early_en;
    exp = ref_prod(sgn, a, b);
    @(negedge clk);
    is_signed = sgn; mode64 = m64; op_a = a; op_b = b; rd = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    early_en = 1'b0;
    while (!done && n < 40) begin
      if (intrude && n == 5) begin
        start = 1'b1; is_signed = ~sgn; mode64 = ~m64; rd = ~d;
        op_a = 64'h1234_5678_9ABC_DEF0; op_b = 64'h0FED_CBA9_8765_4321;
      end else begin
        start = 1'b0;
      end
      if (wr0_en || wr1_en) early_en = 1'b1;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk({tag, " R6 latency"}, 64'(n), 64'd32);
    chk({tag, " R6 no early enable"}, {63'd0, early_en}, 64'd0);
    if (m64) begin
      chk({tag, " R5 wr0_en"}, {63'd0, wr0_en}, 64'd1);
      chk({tag, " R5 wr1_en low"}, {63'd0, wr1_en}, 64'd0);
      chk({tag, " R5 addr"}, {59'd0, wr0_addr}, {59'd0, d});
      chk({tag, " R1/R2 R5 data"}, wr0_data, exp);
    end else begin
      chk({tag, " R4 enables"}, {62'd0, wr0_en, wr1_en}, 64'd3);
      chk({tag, " R4 even addr"}, {59'd0, wr0_addr}, {59'd0, d[4:1], 1'b0});
      chk({tag, " R4 odd addr"}, {59'd0, wr1_addr}, {59'd0, d[4:1], 1'b1});
      chk({tag, " R1/R2 R4 low half"}, wr0_data, {32'd0, exp[31:0]});
      chk({tag, " R1/R2 R4 high half"}, wr1_data, {32'd0, exp[63:32]});
    end
    @(negedge clk);
    chk({tag, " R6 one-cycle done"}, {63'd0, done}, 64'd0);
    if (intrude) begin
      n = 0;
      while (!done && n < 40) begin
        @(negedge clk);
        n++;
      end
      chk({tag, " R7 no extra done"}, {63'd0, done}, 64'd0);
    end
  endtask

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd20240917);
    repeat (3) @(negedge clk);
    chk("R8 reset done", {63'd0, done}, 64'd0);
    chk("R8 reset enables", {62'd0, wr0_en, wr1_en}, 64'd0);
    rst = 1'b0;

    run_op("R1 max unsigned", 1'b0, 1'b0, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 5'd6, 1'b0);
    run_op("R2 min*min", 1'b1, 1'b1, 64'h8000_0000, 64'h8000_0000, 5'd9, 1'b0);
    run_op("R2 min*max", 1'b1, 1'b0, 64'h8000_0000, 64'h7FFF_FFFF, 5'd12, 1'b0);
    run_op("R2 neg one", 1'b1, 1'b1, 64'hFFFF_FFFF, 64'd1, 5'd3, 1'b0);
    run_op("R1 zero", 1'b0, 1'b1, 64'd0, 64'hFFFF_FFFF, 5'd31, 1'b0);
    run_op("R3 upper bits", 1'b1, 1'b1, 64'hDEAD_BEEF_0000_0007, 64'hA5A5_A5A5_FFFF_FFFD, 5'd17, 1'b0);
    run_op("R3 upper bits u", 1'b0, 1'b0, 64'hFFFF_FFFF_0000_0003, 64'h1234_0000_8000_0000, 5'd20, 1'b0);
    run_op("R4 odd rd", 1'b0, 1'b0, 64'h0001_0000, 64'h0003_0001, 5'd7, 1'b0);
    run_op("R9 rd zero", 1'b1, 1'b0, 64'h7FFF_FFFF, 64'h7FFF_FFFF, 5'd0, 1'b0);
    run_op("R9 rd one", 1'b0, 1'b0, 64'h0000_0002, 64'h8000_0001, 5'd1, 1'b0);
    run_op("R9 rd zero wide", 1'b0, 1'b1, 64'h5, 64'h7, 5'd0, 1'b0);
    run_op("R7 start while busy", 1'b1, 1'b0, 64'hFFFF_FFF0, 64'h0000_1000, 5'd10, 1'b1);
    run_op("R7 start while busy wide", 1'b0, 1'b1, 64'hCAFE_0000, 64'h0000_BEEF, 5'd11, 1'b1);

    // R8: reset partway through an operation
    @(negedge clk);
    is_signed = 1'b0; mode64 = 1'b0; op_a = 64'h99; op_b = 64'h77; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R8 mid-op reset done", {63'd0, done}, 64'd0);
    rst = 1'b0;
    begin
      logic seen;
      seen = 1'b0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (done || wr0_en || wr1_en) seen = 1'b1;
      end
      chk("R8 aborted op gives no done", {63'd0, seen}, 64'd0);
    end

    for (int k = 0; k < 40; k++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      if (k % 8 == 0) ra[31:0] = 32'h8000_0000;
      run_op("R1/R2 random", 1'($urandom), 1'($urandom), ra, rb, 5'($urandom), 1'b0);
    end

    finish_run();
  end
endmodule